// File: doc/BRIEF.md
# Startup Output-Short Check Sequencer

This block sequences a one-time check for shorted power outputs that runs when the logic supply first becomes valid, before any switching is allowed. The first step looks for outputs tied to ground. The second step looks for outputs tied to the power rail. The block drives a step-enable strobe for each step to the analog test circuitry, which is outside this block. At the last cycle of each step it samples that circuitry's per-output comparator results. If any output reports a short, the same step repeats, with no limit on the number of repeats. Startup continues only once the step comes back clean.

While a step is active, the status line is held low and every output stays in high impedance. The two bridge-pair reset inputs have no effect during this time. When both steps come back clean, the block raises a pass flag, releases the high-impedance hold and lets the status line go high. A done-once flag keeps the check from running again until the supply-good flag drops. Reset pulses after that point do not restart it. In single-ended modes the check is skipped and pass is raised directly. Each step lasts a programmable number of clock cycles, which the integrator sizes from the output filter capacitance (typically below 15 ms per µF).

Top module: `ostart_short_seq`

## Requirements
- R1: Out of reset with the supply low and both pair resets high, pass is 0, hiz_hold is 1, both step enables are 0 and status_ok is 0.
- R2: In a bridged mode (mode values 000 to 011), step_gnd_en rises one cycle after supply_ok is seen high with the done flag clear. It lasts L cycles per attempt, where L is step_cycles, or 1 when step_cycles is 0.
- R3: After a clean ground step, step_rail_en is high for L cycles per attempt. Pass rises in the cycle after the last clean rail cycle, with hiz_hold 0 and status_ok 1.
- R4: If any bit of gnd_short is high in the last cycle of a ground step, the ground step repeats. The rail step does not start until a ground attempt ends clean. rail_short is ignored during the ground step.
- R5: If any bit of rail_short is high in the last cycle of a rail step, the rail step repeats. gnd_short is ignored during the rail step.
- R6: While either step enable is high, status_ok is 0 and hiz_hold is 1, whatever the pair resets do.
- R7: For any mode with bit 2 set, no step runs, and pass rises one cycle after supply_ok is seen high.
- R8: Once pass is high and the supply stays valid, pulses on either pair reset start no step and do not clear pass.
- R9: When supply_ok drops, pass clears in the next cycle. The next time supply_ok is seen high, the check runs again.
- R10: Outside a step and before pass, status_ok is 1 when either pair reset is low and 0 when both are high.
- R11: The two step enables are never high together.
- R12: When supply_ok drops during a step, both enables are low in the next cycle and pass stays 0. This holds even in the final cycle of the rail step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| supply_ok | input | 1 | Logic supply valid flag |
| mode | input | 3 | Output configuration; 000 to 011 bridged, bit 2 set means single-ended or reserved |
| pair0_rst_n | input | 1 | Active-low reset of the first bridge pair |
| pair1_rst_n | input | 1 | Active-low reset of the second bridge pair |
| step_cycles | input | CNT_W | Length of one step attempt in cycles (0 is treated as 1) |
| gnd_short | input | NUM_OUT | Per-output short-to-ground comparator results |
| rail_short | input | NUM_OUT | Per-output short-to-rail comparator results |
| status_ok | output | 1 | Status line, held low during the check |
| hiz_hold | output | 1 | Keeps all outputs in high impedance until pass |
| step_gnd_en | output | 1 | Enable strobe for the ground-short step |
| step_rail_en | output | 1 | Enable strobe for the rail-short step |
| pass | output | 1 | Check completed or skipped; normal startup may proceed |

## Verification
Two functions can fall in the same cycle: the supply-loss abort and the clean end of the rail step that would raise pass. The bench provokes this by dropping supply_ok during the cycle in which the final rail count is observed. It then judges that pass stays 0 and both enables are low in the next cycle. A second overlap is a comparator short arriving on the last cycle of an attempt while the other step's comparator is also driven. The table vectors drive the inactive step's comparator high throughout and confirm that the step lengths match the restated retry arithmetic exactly.

// File: rtl/ostart_pkg.sv
package ostart_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_GND  = 2'd1,
    ST_RAIL = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // Bridged configurations are the four codes with the top bit clear.
  function automatic logic mode_is_bridge(input logic [2:0] m);
    logic r;
    case (m)
      3'b000, 3'b001, 3'b010, 3'b011: r = 1'b1;
      default:                        r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ostart_step_timer.sv
module ostart_step_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_len;

  // A zero request still gives a one-cycle step.
  function automatic logic [CNT_W-1:0] eff_steps(input logic [CNT_W-1:0] req);
    return (req == '0) ? CNT_W'(1) : req;
  endfunction

  assign eff_len = eff_steps(len);
  assign last    = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= eff_len - CNT_W'(1);
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2
  timer_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/ostart_short_merge.sv
module ostart_short_merge #(
  parameter int unsigned NUM_OUT = 4
) (
  input  logic [NUM_OUT-1:0] gnd_cmp,
  input  logic [NUM_OUT-1:0] rail_cmp,
  input  logic               sel_rail,
  output logic               any_short
);

  logic [NUM_OUT-1:0] picked;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign picked[i] = sel_rail ? rail_cmp[i] : gnd_cmp[i];
  end

  assign any_short = |picked;

endmodule

// File: rtl/ostart_short_seq.sv
module ostart_short_seq import ostart_pkg::*; #(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_ok,
  input  logic [2:0]         mode,
  input  logic               pair0_rst_n,
  input  logic               pair1_rst_n,
  input  logic [CNT_W-1:0]   step_cycles,
  input  logic [NUM_OUT-1:0] gnd_short,
  input  logic [NUM_OUT-1:0] rail_short,
  output logic               status_ok,
  output logic               hiz_hold,
  output logic               step_gnd_en,
  output logic               step_rail_en,
  output logic               pass
);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       bridge_sel;
  logic       start_req;
  logic       timer_load;
  logic       timer_run;
  logic       timer_last;
  logic       any_short;
  logic       in_test;
  logic       pair_reset;

  assign bridge_sel   = mode_is_bridge(mode);
  assign start_req    = (state_q == ST_WAIT) && supply_ok && !done_q;
  assign step_gnd_en  = (state_q == ST_GND);
  assign step_rail_en = (state_q == ST_RAIL);
  assign in_test      = step_gnd_en || step_rail_en;
  assign timer_run    = in_test;
  assign pair_reset   = !pair0_rst_n || !pair1_rst_n;

  ostart_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (timer_load),
    .run   (timer_run),
    .len   (step_cycles),
    .last  (timer_last)
  );

  ostart_short_merge #(.NUM_OUT(NUM_OUT)) u_merge (
    .gnd_cmp   (gnd_short),
    .rail_cmp  (rail_short),
    .sel_rail  (step_rail_en),
    .any_short (any_short)
  );

  always_comb begin
    state_d    = state_q;
    done_d     = done_q;
    timer_load = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (start_req) begin
          if (bridge_sel) begin
            state_d    = ST_GND;
            timer_load = 1'b1;
          end else begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end
        end
      end
      ST_GND: begin
        if (!supply_ok) begin
          state_d = ST_WAIT;
        end else if (timer_last) begin
          timer_load = 1'b1;
          if (!any_short) state_d = ST_RAIL;
        end
      end
      ST_RAIL: begin
        if (!supply_ok) begin
          state_d = ST_WAIT;
        end else if (timer_last) begin
          timer_load = 1'b1;
          if (!any_short) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (!supply_ok) state_d = ST_WAIT;
      end
      default: state_d = ST_WAIT;
    endcase
    if (!supply_ok) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Status: forced low during the check; pair resets only matter outside it.
  always_comb begin
    if (in_test)      status_ok = 1'b0;
    else if (done_q)  status_ok = 1'b1;
    else              status_ok = pair_reset;
  end

  assign hiz_hold = !done_q;
  assign pass     = done_q;

  // R11
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_gnd_en, step_rail_en}));

  // R6
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_gnd_en || step_rail_en) |-> (!status_ok && hiz_hold));

  // R4
  gnd_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_gnd_en && timer_last && any_short && supply_ok) |=> step_gnd_en);

  // R5
  rail_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rail_en && timer_last && any_short && supply_ok) |=> step_rail_en);

  // R2
  rail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_rail_en) |-> $past(step_gnd_en));

  // R3
  pass_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> ($past(step_rail_en) || !$past(bridge_sel)));

  // R8
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && supply_ok) |=> pass);

  // R12
  supply_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!step_gnd_en && !step_rail_en && !pass));

endmodule

// File: tb/ostart_short_seq_tb.sv
module ostart_short_seq_tb;
  localparam int NUM_OUT = 4;
  localparam int CNT_W   = 16;
  localparam int NVEC    = 8;

  // {mode[2:0], cycles[7:0], gnd_retries[3:0], rail_retries[3:0], wiggle_resets}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'b000, 8'd4, 4'd0, 4'd0, 1'b0},
    {3'b001, 8'd3, 4'd2, 4'd0, 1'b1},
    {3'b010, 8'd5, 4'd0, 4'd3, 1'b0},
    {3'b011, 8'd2, 4'd1, 4'd1, 1'b1},
    {3'b100, 8'd4, 4'd0, 4'd0, 1'b0},
    {3'b101, 8'd3, 4'd2, 4'd2, 1'b1},
    {3'b000, 8'd0, 4'd0, 4'd1, 1'b0},
    {3'b011, 8'd1, 4'd3, 4'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               supply_ok = 1'b0;
  logic [2:0]         mode = 3'b000;
  logic               pair0_rst_n = 1'b1;
  logic               pair1_rst_n = 1'b1;
  logic [CNT_W-1:0]   step_cycles = 16'd4;
  logic [NUM_OUT-1:0] gnd_short = '0;
  logic [NUM_OUT-1:0] rail_short = '0;
  logic status_ok, hiz_hold, step_gnd_en, step_rail_en, pass;

  int checks = 0;
  int fails  = 0;

  ostart_short_seq #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mode(mode),
    .pair0_rst_n(pair0_rst_n), .pair1_rst_n(pair1_rst_n),
    .step_cycles(step_cycles), .gnd_short(gnd_short), .rail_short(rail_short),
    .status_ok(status_ok), .hiz_hold(hiz_hold), .step_gnd_en(step_gnd_en),
    .step_rail_en(step_rail_en), .pass(pass)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic power_off();
    supply_ok  = 1'b0;
    gnd_short  = '0;
    rail_short = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [19:0] v);
    logic [2:0] m;
    int cyc, gh, rh, len, g_exp, r_exp, t_exp;
    int ng, nr, steps, bad;
    bit wig, bridge;
    m = v[19:17]; cyc = int'(v[16:9]); gh = int'(v[8:5]); rh = int'(v[4:1]); wig = v[0];
    len    = (cyc == 0) ? 1 : cyc;
    bridge = (m[2] == 1'b0);
    g_exp  = bridge ? len * (gh + 1) : 0;
    r_exp  = bridge ? len * (rh + 1) : 0;
    t_exp  = bridge ? g_exp + r_exp + 1 : 1;
    ng = 0; nr = 0; steps = 0; bad = 0;
    power_off();
    mode = m;
    step_cycles = CNT_W'(cyc);
    supply_ok = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      steps++;
      if (pass) break;
      if ((step_gnd_en || step_rail_en) && (status_ok || !hiz_hold)) bad++;
      if (step_gnd_en) begin
        ng++;
        gnd_short  = (ng <= gh * len) ? NUM_OUT'(1 << (ng % NUM_OUT)) : '0;
        rail_short = '1;
      end else if (step_rail_en) begin
        nr++;
        rail_short = (nr <= rh * len) ? NUM_OUT'(1 << (nr % NUM_OUT)) : '0;
        gnd_short  = '1;
      end
      if (wig) begin
        pair0_rst_n = k[0];
        pair1_rst_n = k[1];
      end
    end
    pair0_rst_n = 1'b1;
    pair1_rst_n = 1'b1;
    @(negedge clk);
    check(ng == g_exp, bridge ? "R2/R4 gnd cycles" : "R7 gnd cycles", ng, g_exp);
    check(nr == r_exp, bridge ? "R3/R5 rail cycles" : "R7 rail cycles", nr, r_exp);
    check(steps == t_exp, bridge ? "R3 pass latency" : "R7 pass latency", steps, t_exp);
    check(bad == 0, "R6 hold during test", bad, 0);
    check(pass && status_ok && !hiz_hold, "R3 released after pass",
          {pass, status_ok, hiz_hold}, 3'b110);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!pass && hiz_hold && !step_gnd_en && !step_rail_en && !status_ok, "R1 reset state",
          {pass, hiz_hold, step_gnd_en, step_rail_en, status_ok}, 5'b01000);

    // R10 status follows pair resets outside the check
    pair0_rst_n = 1'b0;
    @(negedge clk);
    check(status_ok == 1'b1, "R10 pair0 reset", status_ok, 1);
    pair0_rst_n = 1'b1;
    pair1_rst_n = 1'b0;
    @(negedge clk);
    check(status_ok == 1'b1, "R10 pair1 reset", status_ok, 1);
    pair1_rst_n = 1'b1;
    @(negedge clk);
    check(status_ok == 1'b0, "R10 both released", status_ok, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R8 reset pulses after pass start nothing
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      pair0_rst_n = k[0];
      pair1_rst_n = k[1];
      @(negedge clk);
      if (step_gnd_en || step_rail_en || !pass) bad++;
    end
    pair0_rst_n = 1'b1;
    pair1_rst_n = 1'b1;
    check(bad == 0, "R8 no rerun on reset", bad, 0);

    // R9 supply drop clears pass, rise reruns
    supply_ok = 1'b0;
    @(negedge clk);
    check(!pass && hiz_hold, "R9 pass cleared", pass, 0);
    mode = 3'b000;
    step_cycles = 16'd2;
    supply_ok = 1'b1;
    @(negedge clk);
    check(step_gnd_en == 1'b1, "R9 rerun starts", step_gnd_en, 1);

    // R12 abort mid ground step
    power_off();
    step_cycles = 16'd6;
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    check(step_gnd_en == 1'b1, "R12 ground step running", step_gnd_en, 1);
    supply_ok = 1'b0;
    @(negedge clk);
    check(!step_gnd_en && !step_rail_en && !pass, "R12 abort",
          {step_gnd_en, step_rail_en, pass}, 0);

    // R12 collision: supply loss on last clean rail cycle
    power_off();
    step_cycles = 16'd3;
    supply_ok = 1'b1;
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (step_rail_en) bad++;
      if (bad == 3) break;
    end
    check(bad == 3, "R3 rail reached", bad, 3);
    supply_ok = 1'b0;
    @(negedge clk);
    check(!pass && !step_rail_en && !step_gnd_en, "R12 abort beats pass",
          {pass, step_rail_en, step_gnd_en}, 0);
    @(negedge clk);
    check(!pass, "R12 pass stays low", pass, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule